// File: doc/BRIEF.md
# Dual-Timebase Event Rate Cross-Checker

This block watches two periodic event streams that come from independent time bases: a slow heartbeat tick and a fast update tick. Each stream is used to measure the other. At every heartbeat, the number of fast ticks seen since the previous heartbeat is compared against a tolerance window. At the end of every batch of fast ticks, the number of heartbeats seen during that batch is compared against a second window. This catches both a stream that has stopped and a stream that is running too fast, whichever side fails.

An out-of-window result sets a sticky cause bit, and the combined error output goes high. The intended setting is a 10 ms heartbeat next to a 500 µs update event. With that setting, 19 to 21 fast ticks are accepted per heartbeat, and 4 to 6 heartbeats are accepted per batch of 100 fast ticks. All bounds and the batch size are parameters. The tick generators sit outside the block. Each tick input is a single-cycle pulse in the block's clock domain.

Top module: `rate_xcheck`

## Requirements
- R1: While rst_ni is low and after it is released, err_cause_o is 2'b00 and err_o is 0.
- R2: When hb_tick_i is sampled high, the count of fast ticks since the previous heartbeat must lie in [FAST_MIN, FAST_MAX], which defaults to [19, 21]. Otherwise err_cause_o[0] is set.
- R3: The first heartbeat after reset performs no check, because its interval is partial. Any fast-tick count before it leaves err_cause_o[0] clear.
- R4: On the cycle in which the FAST_BATCH-th fast tick of a batch is sampled (default 100), the count of heartbeats in that batch must lie in [HB_MIN, HB_MAX], which defaults to [4, 6]. Otherwise err_cause_o[1] is set.
- R5: Each count restarts from zero at its own check. A tick sampled in the same cycle as the check that closes an interval is counted in the following interval.
- R6: The counts saturate at their all-ones value and do not wrap. A count that overshoots therefore fails its window, even when the wrapped value would have landed inside it.
- R7: Cause bits are sticky until reset, and err_o is high exactly when any cause bit is set.
- R8: A failing check becomes visible on err_cause_o and err_o after the same clock edge that samples the closing tick. Before that edge the outputs show no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hb_tick_i | input | 1 | Slow heartbeat pulse |
| fast_tick_i | input | 1 | Fast update pulse |
| err_o | output | 1 | Any cause bit set |
| err_cause_o | output | 2 | Bit 0: fast count out of window at a heartbeat; bit 1: heartbeat count out of window at a batch end |

## Verification
The heartbeat check and the batch check can fire in the same cycle, when a heartbeat pulse lands on the tick that closes a batch. Each check must then judge its own count, and the coincident ticks must go to the next intervals. The bench provokes this with 99 lone fast ticks interleaved with heartbeats, followed by one cycle that carries both pulses. It expects both checks to pass, and it also runs a variant where both fail at once and both cause bits must rise together. A separate sequence puts a fast tick on a heartbeat so that the outcome flips if that tick is placed in the wrong interval.

// File: rtl/rate_xcheck_pkg.sv
package rate_xcheck_pkg;
  localparam int unsigned CAUSE_FAST = 0;  // fast count window, judged at heartbeat
  localparam int unsigned CAUSE_SLOW = 1;  // heartbeat count window, judged at batch end
  localparam int unsigned CAUSE_W    = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= inc_i ? ONE : '0;  // coincident tick opens next interval
    else if (inc_i && cnt_q != SAT) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_batch_counter.sv
module rx_batch_counter #(
  parameter int unsigned N = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned   W    = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0]  LAST = W'(N - 1);
  localparam logic [W-1:0]  ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = inc_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= at_last ? '0 : cnt_q + ONE;
  end
endmodule

// File: rtl/rx_window.sv
module rx_window #(
  parameter int unsigned W  = 5,
  parameter int unsigned LO = 19,
  parameter int unsigned HI = 21
) (
  input  logic [W-1:0] val_i,
  output logic         ok_o
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  logic lo_ok;

  generate
    if (LO == 0) begin : g_no_lo
      assign lo_ok = 1'b1;
    end else begin : g_lo
      assign lo_ok = (val_i >= LO_V);
    end
  endgenerate

  assign ok_o = lo_ok && (val_i <= HI_V);
endmodule

// File: rtl/rate_xcheck.sv
module rate_xcheck
  import rate_xcheck_pkg::*;
#(
  parameter int unsigned FAST_MIN   = 19,
  parameter int unsigned FAST_MAX   = 21,
  parameter int unsigned FAST_BATCH = 100,
  parameter int unsigned HB_MIN     = 4,
  parameter int unsigned HB_MAX     = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hb_tick_i,
  input  logic               fast_tick_i,
  output logic               err_o,
  output logic [CAUSE_W-1:0] err_cause_o
);
  // one spare code above each upper bound, so saturation always lands outside
  localparam int unsigned FAST_CNT_W = $clog2(FAST_MAX + 2);
  localparam int unsigned HB_CNT_W   = $clog2(HB_MAX + 2);

  logic [FAST_CNT_W-1:0] fast_cnt;
  logic [HB_CNT_W-1:0]   hb_cnt;
  logic                  batch_done;
  logic                  fast_ok, hb_ok;
  logic                  armed_q;
  cause_t                cause_q, cause_set;

  rx_sat_counter #(.W(FAST_CNT_W)) u_fast_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fast_tick_i),
    .clr_i  (hb_tick_i),
    .cnt_o  (fast_cnt)
  );

  rx_sat_counter #(.W(HB_CNT_W)) u_hb_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hb_tick_i),
    .clr_i  (batch_done),
    .cnt_o  (hb_cnt)
  );

  rx_batch_counter #(.N(FAST_BATCH)) u_batch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fast_tick_i),
    .done_o (batch_done)
  );

  rx_window #(.W(FAST_CNT_W), .LO(FAST_MIN), .HI(FAST_MAX)) u_fast_win (
    .val_i (fast_cnt),
    .ok_o  (fast_ok)
  );

  rx_window #(.W(HB_CNT_W), .LO(HB_MIN), .HI(HB_MAX)) u_hb_win (
    .val_i (hb_cnt),
    .ok_o  (hb_ok)
  );

  always_comb begin
    cause_set             = '0;
    cause_set[CAUSE_FAST] = hb_tick_i && armed_q && !fast_ok;
    cause_set[CAUSE_SLOW] = batch_done && !hb_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cause_q <= '0;
    end else begin
      if (hb_tick_i) armed_q <= 1'b1;  // first interval is partial
      cause_q <= cause_q | cause_set;
    end
  end

  assign err_cause_o = cause_q;
  assign err_o       = |cause_q;
endmodule

// File: rtl/rate_xcheck_chk.sv
module rate_xcheck_chk #(
  parameter int unsigned FW = 5,
  parameter int unsigned HW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hb_tick_i,
  input logic          fast_tick_i,
  input logic          err_o,
  input logic [1:0]    err_cause_o,
  input logic [FW-1:0] fast_cnt,
  input logic [HW-1:0] hb_cnt,
  input logic          batch_done
);
  assert_fast_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cause_o[0] |=> err_cause_o[0]);

  assert_slow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cause_o[1] |=> err_cause_o[1]);

  assert_err_follows_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cause_o == 2'b00) |-> !err_o);

  assert_fast_flag_needs_hb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_cause_o[0] && !hb_tick_i) |=> !err_cause_o[0]);

  assert_slow_flag_needs_batch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_cause_o[1] && !batch_done) |=> !err_cause_o[1]);

  assert_slow_batch_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_done |-> fast_tick_i);

  assert_fast_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_tick_i && !fast_tick_i) |=> (fast_cnt == '0));

  assert_fast_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_tick_i && fast_tick_i) |=> (fast_cnt == FW'(1)));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_tick_i && !hb_tick_i) |=> (fast_cnt != '0));

  assert_hb_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_tick_i && !batch_done) |=> (hb_cnt != '0));
endmodule

bind rate_xcheck rate_xcheck_chk #(.FW(FAST_CNT_W), .HW(HB_CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hb_tick_i   (hb_tick_i),
  .fast_tick_i (fast_tick_i),
  .err_o       (err_o),
  .err_cause_o (err_cause_o),
  .fast_cnt    (fast_cnt),
  .hb_cnt      (hb_cnt),
  .batch_done  (batch_done)
);

// File: tb/rate_xcheck_tb.sv
`timescale 1ns/1ps
module rate_xcheck_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hb = 1'b0;
  logic       fast = 1'b0;
  logic       err;
  logic [1:0] cause;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rate_xcheck u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hb_tick_i   (hb),
    .fast_tick_i (fast),
    .err_o       (err),
    .err_cause_o (cause)
  );

  // fast ticks per measured heartbeat interval, and expected cause bit 0
  localparam int   N_VEC = 8;
  localparam int   VEC_N   [N_VEC] = '{0, 5, 18, 19, 20, 21, 22, 52};
  localparam logic VEC_EXP [N_VEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cause actual=%b expected=%b", req, act, exp);
    end
    checks++;
    if (err !== (|exp)) begin
      failures++;
      $display("FAIL %s err_o actual=%b expected=%b", req, err, |exp);
    end
  endtask

  task automatic cyc(input logic h, input logic f);
    hb = h;
    fast = f;
    @(negedge clk);
    hb = 1'b0;
    fast = 1'b0;
  endtask

  task automatic fasts(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    cyc(1'b0, 1'b0);
    chk("R1 in reset", cause, 2'b00);
    do_reset();
    chk("R1 after reset", cause, 2'b00);

    // vector table: partial first interval, then one measured interval
    for (int v = 0; v < N_VEC; v++) begin
      do_reset();
      fasts(3);
      cyc(1'b1, 1'b0);
      chk("R3 first heartbeat skipped", cause, 2'b00);
      fasts(VEC_N[v]);
      chk("R8 no flag before check edge", cause, 2'b00);
      cyc(1'b1, 1'b0);
      chk(VEC_N[v] == 52 ? "R6 saturating fast count" : "R2 fast window", cause, {1'b0, VEC_EXP[v]});
    end

    // R3: a long first interval is still not judged
    do_reset();
    fasts(40);
    cyc(1'b1, 1'b0);
    chk("R3 long partial interval", cause, 2'b00);

    // R4: passing batch, 5 heartbeats
    do_reset();
    cyc(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      fasts(20);
      cyc(1'b1, 1'b0);
    end
    fasts(19);
    chk("R4 before batch end", cause, 2'b00);
    fasts(1);
    chk("R4 batch in window", cause, 2'b00);

    // R4: too few heartbeats (2)
    do_reset();
    fasts(20);
    cyc(1'b1, 1'b0);
    fasts(20);
    cyc(1'b1, 1'b0);
    fasts(59);
    chk("R8 slow flag not early", cause, 2'b00);
    fasts(1);
    chk("R4 too few heartbeats", cause, 2'b10);

    // R6/R4: 12 heartbeats saturate at 7 instead of wrapping to 4
    do_reset();
    for (int k = 0; k < 12; k++) cyc(1'b1, 1'b0);
    fasts(100);
    chk("R6 saturating heartbeat count", cause, 2'b11);

    // R5: coincident fast tick counted in next interval
    do_reset();
    cyc(1'b1, 1'b0);
    fasts(21);
    cyc(1'b1, 1'b1);
    chk("R5 coincident tick excluded", cause, 2'b00);
    fasts(18);
    cyc(1'b1, 1'b0);
    chk("R5 coincident tick carried", cause, 2'b00);

    // both checks in one cycle, both passing
    do_reset();
    cyc(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      fasts(20);
      cyc(1'b1, 1'b0);
    end
    fasts(19);
    cyc(1'b1, 1'b1);
    chk("R5 dual check same cycle pass", cause, 2'b00);

    // both checks in one cycle, both failing
    do_reset();
    cyc(1'b1, 1'b0);
    fasts(99);
    cyc(1'b1, 1'b1);
    chk("R2 R4 dual check same cycle fail", cause, 2'b11);

    // R7: stickiness over later good intervals
    do_reset();
    cyc(1'b1, 1'b0);
    fasts(10);
    cyc(1'b1, 1'b0);
    chk("R2 short interval", cause, 2'b01);
    for (int k = 0; k < 3; k++) begin
      fasts(20);
      cyc(1'b1, 1'b0);
    end
    chk("R7 sticky fast cause", cause, 2'b01);
    do_reset();
    chk("R1 reset clears", cause, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule